// File: doc/BRIEF.md
# Write-Protected Subsystem ID Register

This block holds a 32-bit identification doubleword in configuration space. The low half is a 16-bit vendor identifier at byte offset 40h, and the high half is a 16-bit subsystem identifier at byte offset 42h. A single write-protect bit decides whether host configuration writes may change the doubleword. That bit lives at bit 5 of the dword at byte offset 80h. It comes up set, so after reset the identifier is read-only to the host. Firmware clears the bit, writes the identifier, and sets the bit again to lock it.

When reset ends, a small sequencer asks an external serial-memory engine for the value. The request and reply use a plain request / valid-data / absent handshake. The engine either returns a whole doubleword, which is stored, or reports that no memory is fitted, in which case the identifier keeps its reset value of zero. While the sequencer waits, host writes to the identifier are dropped, and this includes a write that lands in the same cycle as the engine's data.

A suspend input masks the primary reset from the whole block, including the sequencer. While suspend is high, a pulse on the reset pin leaves the stored identifier, the protect bit and the finished load untouched. Configuration addresses are dword indices, so byte offset 40h is index 10h and byte offset 80h is index 20h. Reads return data in the same cycle.

Top module: `ssid_cfg_block`

## Requirements
- R1: While reset is applied with suspend low, the identifier reads 00000000h, the control dword reads 00000020h (protect bit set), and neither ld_req_o nor ld_done_o is high.
- R2: While the protect bit (bit 5 at dword index 20h) is 1, host writes to dword index 10h leave the identifier unchanged.
- R3: A host write to index 20h with byte enable bit 0 set loads the protect bit from wdata bit 5. A write without byte enable bit 0 leaves the protect bit unchanged. Reads of index 20h return the protect bit in bit 5 and zero in every other bit.
- R4: While the protect bit is 0 and no load is pending, a write to index 10h updates only the byte lanes whose byte enables are set. Lanes 0-1 hold the vendor ID (offset 40h) and lanes 2-3 hold the subsystem ID (offset 42h).
- R5: In the first cycle after reset is released, ld_req_o is low. From the next cycle, ld_req_o stays high until ld_valid_i or ld_absent_i is seen. In the following cycle, ld_req_o is low and ld_done_o is high, and ld_done_o then stays high until the next reset.
- R6: ld_valid_i seen while ld_req_o is high stores all 32 bits of ld_data_i, whatever the state of the protect bit. A host write to index 10h in any cycle while ld_req_o is high, including the same cycle, is ignored.
- R7: ld_absent_i seen while ld_req_o is high ends the load and leaves the identifier at 00000000h.
- R8: While suspend_i is high, asserting rst_n low changes neither the identifier, the protect bit nor ld_done_o, and no new load request is raised.
- R9: cfg_rdata_o is zero when cfg_rd_i is low, and it is zero for any index other than 10h and 20h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Primary reset, active low, gated by suspend |
| suspend_i | input | 1 | High masks rst_n from the block |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_rd_i | input | 1 | Configuration read strobe |
| cfg_dw_addr_i | input | 6 | Dword index (byte offset / 4) |
| cfg_be_i | input | 4 | Write byte enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, same cycle |
| ld_req_o | output | 1 | Load request to the serial-memory engine |
| ld_valid_i | input | 1 | Engine returns a doubleword |
| ld_absent_i | input | 1 | Engine reports no memory fitted |
| ld_data_i | input | 32 | Doubleword from the engine |
| ld_done_o | output | 1 | Load sequence finished |

## Verification
Two functions can land in the same cycle: the engine delivering its doubleword and a host write to the identifier. The bench first clears the protect bit while the load is still pending, so that only the pending load can block the host write. It then drives ld_valid_i and a full-lane host write to index 10h on the same clock. A read on the following cycle must return the engine's value and nothing from the host data. A separate host write made earlier in the pending window must also leave the value at zero, which shows that the drop does not depend on the data arriving.

// File: rtl/ssid_pkg.sv
package ssid_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_LOADING = 2'd1,
      SEQ_DONE    = 2'd2
   } seq_state_e;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/ssid_load_seq.sv
module ssid_load_seq
   import ssid_pkg::*;
#(
   parameter bit LOAD_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld_valid_i,
   input  logic       ld_absent_i,
   output seq_state_e state_o,
   output logic       ld_we_o
);

   seq_state_e state_q, state_d;

   generate
      if (LOAD_EN) begin : g_load
         always_comb begin
            state_d = state_q;
            ld_we_o = 1'b0;
            case (state_q)
               SEQ_IDLE:    state_d = SEQ_LOADING;
               SEQ_LOADING: begin
                  if (ld_valid_i) begin
                     ld_we_o = 1'b1;
                     state_d = SEQ_DONE;
                  end else if (ld_absent_i) begin
                     state_d = SEQ_DONE;
                  end
               end
               SEQ_DONE:    state_d = SEQ_DONE;
               default:     state_d = SEQ_IDLE;
            endcase
         end
      end else begin : g_noload
         always_comb begin
            ld_we_o = 1'b0;
            state_d = SEQ_DONE;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   // R5
   load_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_LOADING && (ld_valid_i || ld_absent_i)) |=> (state_q == SEQ_DONE))
      else $error("load did not finish");

   // R8
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_DONE) |=> (state_q == SEQ_DONE))
      else $error("done state left without reset");

endmodule

// File: rtl/ssid_wp_ctrl.sv
module ssid_wp_ctrl #(
   parameter bit WP_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic val_i,
   output logic wp_o
);

   logic wp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    wp_q <= WP_RST;
      else if (wr_i) wp_q <= val_i;
   end

   assign wp_o = wp_q;

   // R3
   wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(wp_q))
      else $error("protect bit moved without write");

   // R3
   wp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (wp_q == $past(val_i)))
      else $error("protect bit not loaded");

endmodule

// File: rtl/ssid_id_store.sv
module ssid_id_store
   import ssid_pkg::*;
#(
   parameter int unsigned ID_W   = 32,
   parameter logic [ID_W-1:0] ID_RST = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_we_i,
   input  logic [ID_W/BYTE_W-1:0]     be_i,
   input  logic [ID_W-1:0]            wdata_i,
   input  logic                       ld_we_i,
   input  logic [ID_W-1:0]            ld_data_i,
   output logic [ID_W-1:0]            id_o
);

   localparam int unsigned NB = ID_W / BYTE_W;

   generate
      for (genvar b = 0; b < NB; b++) begin : g_lane
         logic [BYTE_W-1:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lane_q <= ID_RST[b*BYTE_W +: BYTE_W];
            else if (ld_we_i)
               lane_q <= ld_data_i[b*BYTE_W +: BYTE_W];
            else if (host_we_i && be_i[b])
               lane_q <= wdata_i[b*BYTE_W +: BYTE_W];
         end
         assign id_o[b*BYTE_W +: BYTE_W] = lane_q;
      end
   endgenerate

   // R6
   load_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we_i |=> (id_o == $past(ld_data_i)))
      else $error("loaded value not stored");

endmodule

// File: rtl/ssid_cfg_block.sv
module ssid_cfg_block
   import ssid_pkg::*;
#(
   parameter int unsigned ID_W      = 32,
   parameter int unsigned DW_ADDR_W = 6,
   parameter logic [DW_ADDR_W-1:0] ID_DW   = 6'h10,
   parameter logic [DW_ADDR_W-1:0] CTRL_DW = 6'h20,
   parameter int unsigned WP_BIT    = 5,
   parameter bit          LOAD_EN   = 1'b1,
   parameter logic [ID_W-1:0] ID_RST = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   suspend_i,
   input  logic                   cfg_wr_i,
   input  logic                   cfg_rd_i,
   input  logic [DW_ADDR_W-1:0]   cfg_dw_addr_i,
   input  logic [ID_W/8-1:0]      cfg_be_i,
   input  logic [ID_W-1:0]        cfg_wdata_i,
   output logic [ID_W-1:0]        cfg_rdata_o,
   output logic                   ld_req_o,
   input  logic                   ld_valid_i,
   input  logic                   ld_absent_i,
   input  logic [ID_W-1:0]        ld_data_i,
   output logic                   ld_done_o
);

   localparam int unsigned NB      = ID_W / BYTE_W;
   localparam int unsigned WP_LANE = WP_BIT / BYTE_W;

   initial begin
      width_ok_chk: assert (ID_W % BYTE_W == 0 && ID_W >= 2*BYTE_W)
         else $error("ID_W must be a whole number of bytes");
      wpbit_ok_chk: assert (WP_BIT < ID_W)
         else $error("WP_BIT outside control dword");
      addr_ok_chk: assert (ID_DW != CTRL_DW)
         else $error("register indices collide");
   end

   // suspend masks the primary reset from every flop in the block
   logic core_rst_n;
   assign core_rst_n = rst_n | suspend_i;

   seq_state_e seq_state;
   logic       ld_we;
   logic       wp_q;
   logic [ID_W-1:0] id_q;

   logic id_hit, ctrl_hit, host_id_we, ctrl_we;
   assign id_hit     = (cfg_dw_addr_i == ID_DW);
   assign ctrl_hit   = (cfg_dw_addr_i == CTRL_DW);
   assign host_id_we = cfg_wr_i && id_hit && !wp_q && (seq_state != SEQ_LOADING);
   assign ctrl_we    = cfg_wr_i && ctrl_hit && cfg_be_i[WP_LANE];

   ssid_load_seq #(.LOAD_EN(LOAD_EN)) u_seq (
      .clk         (clk),
      .rst_n       (core_rst_n),
      .ld_valid_i  (ld_valid_i),
      .ld_absent_i (ld_absent_i),
      .state_o     (seq_state),
      .ld_we_o     (ld_we)
   );

   ssid_wp_ctrl #(.WP_RST(1'b1)) u_wp (
      .clk   (clk),
      .rst_n (core_rst_n),
      .wr_i  (ctrl_we),
      .val_i (cfg_wdata_i[WP_BIT]),
      .wp_o  (wp_q)
   );

   ssid_id_store #(.ID_W(ID_W), .ID_RST(ID_RST)) u_store (
      .clk       (clk),
      .rst_n     (core_rst_n),
      .host_we_i (host_id_we),
      .be_i      (cfg_be_i[NB-1:0]),
      .wdata_i   (cfg_wdata_i),
      .ld_we_i   (ld_we),
      .ld_data_i (ld_data_i),
      .id_o      (id_q)
   );

   always_comb begin
      cfg_rdata_o = '0;
      if (cfg_rd_i) begin
         if (id_hit)        cfg_rdata_o = id_q;
         else if (ctrl_hit) cfg_rdata_o[WP_BIT] = wp_q;
      end
   end

   assign ld_req_o  = (seq_state == SEQ_LOADING);
   assign ld_done_o = (seq_state == SEQ_DONE);

   // R2
   locked_id_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
      (cfg_wr_i && id_hit && wp_q && !ld_req_o) |=> $stable(id_q))
      else $error("protected identifier changed");

   // R6
   pending_drop_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
      (ld_req_o && !ld_valid_i) |=> $stable(id_q))
      else $error("identifier changed while load pending");

endmodule

// File: tb/ssid_cfg_block_bench.sv
module ssid_cfg_block_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        suspend_i = 1'b0;
   logic        cfg_wr_i = 1'b0;
   logic        cfg_rd_i = 1'b0;
   logic [5:0]  cfg_dw_addr_i = '0;
   logic [3:0]  cfg_be_i = '0;
   logic [31:0] cfg_wdata_i = '0;
   logic [31:0] cfg_rdata_o;
   logic        ld_req_o;
   logic        ld_valid_i = 1'b0;
   logic        ld_absent_i = 1'b0;
   logic [31:0] ld_data_i = '0;
   logic        ld_done_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ssid_cfg_block u_ssid_cfg_block (
      .clk(clk), .rst_n(rst_n), .suspend_i(suspend_i),
      .cfg_wr_i(cfg_wr_i), .cfg_rd_i(cfg_rd_i), .cfg_dw_addr_i(cfg_dw_addr_i),
      .cfg_be_i(cfg_be_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
      .ld_req_o(ld_req_o), .ld_valid_i(ld_valid_i), .ld_absent_i(ld_absent_i),
      .ld_data_i(ld_data_i), .ld_done_o(ld_done_o)
   );

   typedef struct packed {
      logic        is_wr;
      logic [5:0]  addr;
      logic [3:0]  be;
      logic [31:0] data;   // write data, or expected read data
      logic [15:0] tag;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [0:NV-1] = '{
      '{1'b1, 6'h10, 4'hF, 32'h1111_2222, "R2"},
      '{1'b0, 6'h10, 4'h0, 32'hA5A5_1234, "R2"},
      '{1'b1, 6'h20, 4'h1, 32'h0000_0000, "R3"},
      '{1'b0, 6'h20, 4'h0, 32'h0000_0000, "R3"},
      '{1'b1, 6'h10, 4'h3, 32'h0000_BEEF, "R4"},
      '{1'b0, 6'h10, 4'h0, 32'hA5A5_BEEF, "R4"},
      '{1'b1, 6'h10, 4'hC, 32'hCAFE_0000, "R4"},
      '{1'b0, 6'h10, 4'h0, 32'hCAFE_BEEF, "R4"},
      '{1'b1, 6'h10, 4'h2, 32'h0000_7700, "R4"},
      '{1'b0, 6'h10, 4'h0, 32'hCAFE_77EF, "R4"},
      '{1'b1, 6'h20, 4'h1, 32'hFFFF_FFFF, "R3"},
      '{1'b0, 6'h20, 4'h0, 32'h0000_0020, "R3"},
      '{1'b1, 6'h20, 4'hE, 32'h0000_0000, "R3"},
      '{1'b0, 6'h20, 4'h0, 32'h0000_0020, "R3"},
      '{1'b1, 6'h10, 4'hF, 32'h0000_0000, "R2"},
      '{1'b0, 6'h10, 4'h0, 32'hCAFE_77EF, "R2"},
      '{1'b0, 6'h11, 4'h0, 32'h0000_0000, "R9"},
      '{1'b0, 6'h00, 4'h0, 32'h0000_0000, "R9"}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_i = 1'b1; cfg_dw_addr_i = a; cfg_be_i = be; cfg_wdata_i = d;
      @(negedge clk);
      cfg_wr_i = 1'b0; cfg_be_i = '0;
   endtask

   task automatic host_rd(input string req, input logic [5:0] a, input logic [31:0] exp);
      @(negedge clk);
      cfg_rd_i = 1'b1; cfg_dw_addr_i = a;
      #1;
      check(req, cfg_rdata_o, exp);
      cfg_rd_i = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      host_rd("R1", 6'h10, 32'h0);
      host_rd("R1", 6'h20, 32'h20);
      check("R1", {30'd0, ld_req_o, ld_done_o}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R5", {31'd0, ld_req_o}, 32'h0);
      @(negedge clk);
      #1;
      check("R5", {31'd0, ld_req_o}, 32'h1);
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // reset and first load, with a host write colliding with the data
      do_reset();
      host_wr(6'h20, 4'h1, 32'h0);              // clear protect during load
      host_rd("R3", 6'h20, 32'h0);
      host_wr(6'h10, 4'hF, 32'hDEAD_DEAD);      // dropped: load pending
      host_rd("R6", 6'h10, 32'h0);
      check("R5", {31'd0, ld_req_o}, 32'h1);
      @(negedge clk);
      ld_valid_i = 1'b1; ld_data_i = 32'hA5A5_1234;
      cfg_wr_i = 1'b1; cfg_dw_addr_i = 6'h10; cfg_be_i = 4'hF; cfg_wdata_i = 32'h1111_1111;
      @(negedge clk);
      ld_valid_i = 1'b0; cfg_wr_i = 1'b0; cfg_be_i = '0;
      #1;
      check("R5", {30'd0, ld_req_o, ld_done_o}, 32'h1);
      host_rd("R6", 6'h10, 32'hA5A5_1234);
      host_wr(6'h20, 4'h1, 32'h20);             // lock again

      // vector table
      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_wr)
            host_wr(VECS[i].addr, VECS[i].be, VECS[i].data);
         else
            host_rd(string'(VECS[i].tag), VECS[i].addr, VECS[i].data);
      end

      // read strobe low gives zero
      @(negedge clk);
      cfg_rd_i = 1'b0; cfg_dw_addr_i = 6'h10;
      #1;
      check("R9", cfg_rdata_o, 32'h0);

      // absent memory
      do_reset();
      @(negedge clk);
      ld_absent_i = 1'b1;
      @(negedge clk);
      ld_absent_i = 1'b0;
      #1;
      check("R7", {30'd0, ld_req_o, ld_done_o}, 32'h1);
      host_rd("R7", 6'h10, 32'h0);

      // suspend masks reset
      host_wr(6'h20, 4'h1, 32'h0);
      host_wr(6'h10, 4'hF, 32'h1357_9BDF);
      @(negedge clk);
      suspend_i = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      host_rd("R8", 6'h10, 32'h1357_9BDF);
      host_rd("R8", 6'h20, 32'h0);
      check("R8", {30'd0, ld_req_o, ld_done_o}, 32'h1);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      check("R8", {30'd0, ld_req_o, ld_done_o}, 32'h1);
      host_rd("R8", 6'h10, 32'h1357_9BDF);
      @(negedge clk);
      suspend_i = 1'b0;

      // plain reset again clears everything
      do_reset();

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule